// File: doc/BRIEF.md
# Write Data Byte Mask Unit

This block sits on the write path of a DRAM-style device model, between the capture of write data and the storage array. Each write burst carries eight double-data-rate beats. The capture stage delivers them two at a time on one clock: a rising-edge lane and a falling-edge lane. Each lane brings its own active-low per-byte mask bits. For every beat the unit produces a byte-enable vector, which the array uses to decide which bytes it stores. It also trims the data to the configured device width and tags each beat with its position in the burst.

A write command opens a burst. After that, each cycle with the input-valid flag high delivers one pair of beats, until four pairs have been taken. The device width (x4, x8 or x16) and a mask-enable mode bit are read for every beat pair. In x16 mode, each byte lane has its own mask bit. In x8 mode, a single mask bit controls the low byte. In x4 mode, masking does not exist. Every result is registered and appears one clock after its input pair, qualified by an output-valid flag.

Top module: `wdm_byte_mask`

## Requirements
- R1: While reset is asserted, and after reset until the first accepted pair, outValid is 0.
- R2: A wrCmd seen while no burst is open opens one. The pair on that same cycle is not taken. While the burst is open, each cycle with inValid high takes one beat pair, and the burst closes after the fourth pair. inValid outside a burst produces no output. wrCmd while a burst is open has no effect.
- R3: outValid is 1 exactly in the cycle after a pair is taken, and the outputs carry that pair's results.
- R4: In the k-th pair of a burst (k = 0..3), the rising beat has index 2k and the falling beat has index 2k+1.
- R5: With cfgWidth = 2 (x16) and maskEnable = 1, enable bit 1 (data bits 15:8) equals mask bit 1 and enable bit 0 (bits 7:0) equals mask bit 0. A LOW mask bit gives enable 0, which blocks the byte.
- R6: Rising-beat enables come only from riseMaskN, and falling-beat enables come only from fallMaskN.
- R7: With cfgWidth = 1 (x8) and maskEnable = 1, enable bit 0 equals mask bit 0. Enable bit 1 is 0 and output data bits 15:8 are 0.
- R8: With cfgWidth = 0 (x4), the enables are 2'b01 whatever the mask bits and maskEnable are, and output data bits 15:4 are 0.
- R9: With maskEnable = 0, every lane that the width uses has enable 1, whatever the mask bits are.
- R10: cfgWidth = 3 behaves exactly as x16.
- R11: Data bits inside the configured width pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrCmd | input | 1 | Write command; opens a burst |
| inValid | input | 1 | A beat pair is present on the inputs |
| cfgWidth | input | 2 | Device width: 0 = x4, 1 = x8, 2 or 3 = x16 |
| maskEnable | input | 1 | Mode bit that enables masking |
| riseData | input | 16 | Rising-edge beat data |
| fallData | input | 16 | Falling-edge beat data |
| riseMaskN | input | 2 | Active-low byte masks for the rising beat |
| fallMaskN | input | 2 | Active-low byte masks for the falling beat |
| outValid | output | 1 | Output pair valid |
| outRiseIdx | output | 3 | Burst index of the rising beat |
| outFallIdx | output | 3 | Burst index of the falling beat |
| outRiseData | output | 16 | Width-trimmed rising beat data |
| outFallData | output | 16 | Width-trimmed falling beat data |
| outRiseEn | output | 2 | Byte enables for the rising beat |
| outFallEn | output | 2 | Byte enables for the falling beat |

## Verification
A wrong pair counter or burst-open flag shows at the ports within one cycle. It can appear as a wrong beat index, as an output pair after the fourth, or as a missing output for an accepted pair. The bench feeds inValid gaps, stray commands and out-of-burst pairs to provoke these. A fault in the width or mask decode shows as a wrong enable or as non-zero trimmed bits on the very next valid output. Every width, both mode settings and distinct rise and fall masks are swept so that each lane and edge is seen on its own.

// File: rtl/wdm_pkg.sv
package wdm_pkg;
  localparam int LANE_W    = 8;
  localparam int LANES     = 2;
  localparam int DATA_W    = LANE_W * LANES;
  localparam int BURST_LEN = 8;
  localparam int PAIRS     = BURST_LEN / 2;
  localparam int PAIR_W    = $clog2(PAIRS);
  localparam int IDX_W     = PAIR_W + 1;

  typedef enum logic [1:0] {
    WID_X4   = 2'd0,
    WID_X8   = 2'd1,
    WID_X16  = 2'd2,
    WID_X16B = 2'd3
  } widthMode_e;

  typedef struct packed {
    logic             capture;
    logic [IDX_W-1:0] riseIdx;
  } beatStrobe_t;
endpackage

// File: rtl/wdm_ctrl.sv
module wdm_ctrl
  import wdm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrCmd,
  input  logic        inValid,
  output beatStrobe_t strobe,
  output logic        burstOpen
);
  localparam logic [PAIR_W-1:0] LAST_PAIR = PAIR_W'(PAIRS - 1);

  logic [PAIR_W-1:0] pairCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstOpen <= 1'b0;
      pairCnt   <= '0;
    end else if (!burstOpen) begin
      if (wrCmd) begin
        burstOpen <= 1'b1;
        pairCnt   <= '0;
      end
    end else if (inValid) begin
      if (pairCnt == LAST_PAIR) burstOpen <= 1'b0;
      pairCnt <= pairCnt + 1'b1;
    end
  end

  assign strobe.capture = burstOpen && inValid;
  assign strobe.riseIdx = {pairCnt, 1'b0};

  // R2: the burst closes after its last pair
  p_close_last_r2: assert property (@(posedge clk) disable iff (!rstN)
    (burstOpen && inValid && pairCnt == LAST_PAIR) |=> !burstOpen);

  // R2: an open burst stays open until its last pair, whatever wrCmd does
  p_stay_open_r2: assert property (@(posedge clk) disable iff (!rstN)
    (burstOpen && !(inValid && pairCnt == LAST_PAIR)) |=> burstOpen);
endmodule

// File: rtl/wdm_datapath.sv
module wdm_datapath
  import wdm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  beatStrobe_t       strobe,
  input  logic [1:0]        cfgWidth,
  input  logic              maskEnable,
  input  logic [DATA_W-1:0] riseData,
  input  logic [DATA_W-1:0] fallData,
  input  logic [LANES-1:0]  riseMaskN,
  input  logic [LANES-1:0]  fallMaskN,
  output logic              outValid,
  output logic [IDX_W-1:0]  outRiseIdx,
  output logic [IDX_W-1:0]  outFallIdx,
  output logic [DATA_W-1:0] outRiseData,
  output logic [DATA_W-1:0] outFallData,
  output logic [LANES-1:0]  outRiseEn,
  output logic [LANES-1:0]  outFallEn
);
  widthMode_e widthMode;
  logic       fullWidth;
  logic       maskLive;
  logic [DATA_W-1:0] keepBits;

  assign widthMode = widthMode_e'(cfgWidth);
  assign fullWidth = (widthMode == WID_X16) || (widthMode == WID_X16B);
  assign maskLive  = maskEnable && (widthMode != WID_X4);

  always_comb begin
    unique case (widthMode)
      WID_X4:  keepBits = {{(DATA_W-4){1'b0}}, 4'hF};
      WID_X8:  keepBits = {{(DATA_W-LANE_W){1'b0}}, {LANE_W{1'b1}}};
      default: keepBits = '1;
    endcase
  end

  logic [1:0][DATA_W-1:0] edgeData;
  logic [1:0][LANES-1:0]  edgeMaskN;
  logic [1:0][DATA_W-1:0] dataNext;
  logic [1:0][LANES-1:0]  enNext;

  assign edgeData[0]  = riseData;
  assign edgeData[1]  = fallData;
  assign edgeMaskN[0] = riseMaskN;
  assign edgeMaskN[1] = fallMaskN;

  for (genvar e = 0; e < 2; e++) begin : g_edge
    assign dataNext[e] = edgeData[e] & keepBits;
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic laneUsed;
      logic laneMaskBit;
      assign laneUsed    = fullWidth || (l == 0);
      assign laneMaskBit = fullWidth ? edgeMaskN[e][l] : edgeMaskN[e][0];
      assign enNext[e][l] = laneUsed && (!maskLive || laneMaskBit);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      outRiseIdx  <= '0;
      outFallIdx  <= '0;
      outRiseData <= '0;
      outFallData <= '0;
      outRiseEn   <= '0;
      outFallEn   <= '0;
    end else begin
      outValid <= strobe.capture;
      if (strobe.capture) begin
        outRiseIdx  <= strobe.riseIdx;
        outFallIdx  <= strobe.riseIdx | IDX_W'(1);
        outRiseData <= dataNext[0];
        outFallData <= dataNext[1];
        outRiseEn   <= enNext[0];
        outFallEn   <= enNext[1];
      end
    end
  end

  // R8: narrow nibble device always writes its single lane
  p_x4_enable_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && widthMode == WID_X4) |=>
      (outRiseEn == LANES'(1) && outFallEn == LANES'(1)));

  // R9: masking off in full width opens every lane
  p_no_mask_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && !maskEnable && fullWidth) |=>
      (outRiseEn == '1 && outFallEn == '1));

  // R7: byte-wide device leaves the upper lane idle and zeroed
  p_x8_upper_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && widthMode == WID_X8) |=>
      (!outRiseEn[LANES-1] && !outFallEn[LANES-1] &&
       outRiseData[DATA_W-1:LANE_W] == '0 && outFallData[DATA_W-1:LANE_W] == '0));
endmodule

// File: rtl/wdm_byte_mask.sv
module wdm_byte_mask
  import wdm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrCmd,
  input  logic              inValid,
  input  logic [1:0]        cfgWidth,
  input  logic              maskEnable,
  input  logic [DATA_W-1:0] riseData,
  input  logic [DATA_W-1:0] fallData,
  input  logic [LANES-1:0]  riseMaskN,
  input  logic [LANES-1:0]  fallMaskN,
  output logic              outValid,
  output logic [IDX_W-1:0]  outRiseIdx,
  output logic [IDX_W-1:0]  outFallIdx,
  output logic [DATA_W-1:0] outRiseData,
  output logic [DATA_W-1:0] outFallData,
  output logic [LANES-1:0]  outRiseEn,
  output logic [LANES-1:0]  outFallEn
);
  beatStrobe_t strobe;
  logic        burstOpen;

  wdm_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrCmd     (wrCmd),
    .inValid   (inValid),
    .strobe    (strobe),
    .burstOpen (burstOpen)
  );

  wdm_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .cfgWidth    (cfgWidth),
    .maskEnable  (maskEnable),
    .riseData    (riseData),
    .fallData    (fallData),
    .riseMaskN   (riseMaskN),
    .fallMaskN   (fallMaskN),
    .outValid    (outValid),
    .outRiseIdx  (outRiseIdx),
    .outFallIdx  (outFallIdx),
    .outRiseData (outRiseData),
    .outFallData (outFallData),
    .outRiseEn   (outRiseEn),
    .outFallEn   (outFallEn)
  );

  // R3: a valid output pair always follows an input pair
  p_valid_follows_r3: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid));

  // R2: nothing leaves the block while no burst is open
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !burstOpen |=> !outValid);
endmodule

// File: tb/wdm_byte_mask_tb.sv
module wdm_byte_mask_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrCmd = 1'b0, inValid = 1'b0, maskEnable = 1'b0;
  logic [1:0] cfgWidth = 2'd0;
  logic [15:0] riseData = '0, fallData = '0;
  logic [1:0] riseMaskN = '0, fallMaskN = '0;
  logic outValid;
  logic [2:0] outRiseIdx, outFallIdx;
  logic [15:0] outRiseData, outFallData;
  logic [1:0] outRiseEn, outFallEn;

  int nChecks = 0;
  int nFail = 0;

  // behavioural model state
  bit mOpen = 0;
  int mPair = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdm_byte_mask u_dut (
    .clk(clk), .rstN(rstN), .wrCmd(wrCmd), .inValid(inValid),
    .cfgWidth(cfgWidth), .maskEnable(maskEnable),
    .riseData(riseData), .fallData(fallData),
    .riseMaskN(riseMaskN), .fallMaskN(fallMaskN),
    .outValid(outValid), .outRiseIdx(outRiseIdx), .outFallIdx(outFallIdx),
    .outRiseData(outRiseData), .outFallData(outFallData),
    .outRiseEn(outRiseEn), .outFallEn(outFallEn)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
  endtask

  function automatic logic [1:0] refEn(input logic [1:0] m, input logic [1:0] w, input bit me);
    if (w == 2'd0) return 2'b01;
    if (w == 2'd1) return me ? {1'b0, m[0]} : 2'b01;
    return me ? m : 2'b11;
  endfunction

  function automatic logic [15:0] refData(input logic [15:0] d, input logic [1:0] w);
    if (w == 2'd0) return d & 16'h000F;
    if (w == 2'd1) return d & 16'h00FF;
    return d;
  endfunction

  function automatic string enTag(input logic [1:0] w, input bit me, input bit fallEdge);
    if (w == 2'd0) return "R8";
    if (!me) return "R9";
    if (w == 2'd1) return "R7";
    if (w == 2'd3) return "R10";
    return fallEdge ? "R6" : "R5";
  endfunction

  // one clock: model the current inputs, then compare after the edge
  task automatic tick();
    bit take;
    logic [2:0] eRi, eFi;
    logic [15:0] eRd, eFd;
    logic [1:0] eRe, eFe;
    string vTag, enR, enF;
    take = mOpen && inValid;
    vTag = (inValid && !mOpen) ? "R2" : "R3";
    eRi = 3'(2 * mPair);
    eFi = 3'(2 * mPair + 1);
    eRd = refData(riseData, cfgWidth);
    eFd = refData(fallData, cfgWidth);
    eRe = refEn(riseMaskN, cfgWidth, maskEnable);
    eFe = refEn(fallMaskN, cfgWidth, maskEnable);
    enR = enTag(cfgWidth, maskEnable, 1'b0);
    enF = enTag(cfgWidth, maskEnable, 1'b1);
    if (!mOpen) begin
      if (wrCmd) begin mOpen = 1; mPair = 0; end
    end else if (inValid) begin
      if (mPair == 3) mOpen = 0;
      mPair++;
    end
    @(posedge clk);
    @(negedge clk);
    chk(vTag, "outValid", 32'(outValid), 32'(take));
    if (take) begin
      chk("R4", "riseIdx", 32'(outRiseIdx), 32'(eRi));
      chk("R4", "fallIdx", 32'(outFallIdx), 32'(eFi));
      chk("R11", "riseData", 32'(outRiseData), 32'(eRd));
      chk("R11", "fallData", 32'(outFallData), 32'(eFd));
      chk(enR, "riseEn", 32'(outRiseEn), 32'(eRe));
      chk(enF, "fallEn", 32'(outFallEn), 32'(eFe));
    end
  endtask

  task automatic setIn(input bit wr, input bit v, input logic [1:0] w, input bit me,
                       input logic [15:0] rd, input logic [15:0] fd,
                       input logic [1:0] rm, input logic [1:0] fm);
    wrCmd = wr; inValid = v; cfgWidth = w; maskEnable = me;
    riseData = rd; fallData = fd; riseMaskN = rm; fallMaskN = fm;
  endtask

  task automatic burst(input logic [1:0] w, input bit me, input int seed, input bit gap);
    setIn(1, 0, w, me, 0, 0, 0, 0);
    tick();
    for (int k = 0; k < 4; k++) begin
      if (gap && k == 2) begin
        setIn(0, 0, w, me, 16'hFFFF, 16'hFFFF, 0, 0);
        tick();
      end
      setIn(0, 1, w, me, 16'(seed * 16'h1357 + k * 16'h2468),
            16'(seed * 16'h9ABD + k * 16'h0F1E),
            2'(k + seed), 2'(~(k + seed) ^ 2'b01));
      tick();
    end
    setIn(0, 0, w, me, 0, 0, 0, 0);
    tick();
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    report();
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    chk("R1", "outValid in reset", 32'(outValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "outValid after reset", 32'(outValid), 0);

    // R2: pair outside any burst is dropped
    setIn(0, 1, 2'd2, 1, 16'hABCD, 16'h1234, 2'b01, 2'b10);
    tick();

    // R5/R6: full width, masking on, distinct edge masks, with gap
    burst(2'd2, 1, 1, 0);
    burst(2'd2, 1, 2, 1);
    // R7: byte-wide device
    burst(2'd1, 1, 3, 0);
    burst(2'd1, 1, 4, 0);
    // R8: narrow device ignores masks and mode bit
    burst(2'd0, 1, 5, 0);
    burst(2'd0, 0, 6, 0);
    // R9: masking disabled
    burst(2'd2, 0, 7, 0);
    burst(2'd1, 0, 8, 0);
    // R10: alternate full-width code
    burst(2'd3, 1, 9, 1);

    // R2: command with pair on same idle cycle does not take that pair
    setIn(1, 1, 2'd2, 1, 16'h5555, 16'hAAAA, 2'b10, 2'b01);
    tick();
    // R2: command during open burst is ignored; burst ends after four pairs
    for (int k = 0; k < 4; k++) begin
      setIn(k == 1 || k == 3, 1, 2'd2, 1, 16'(k * 16'h1111), 16'(k * 16'h0101),
            2'(k), 2'(3 - k));
      tick();
    end
    // R2: pair right after close must not produce output
    setIn(0, 1, 2'd2, 1, 16'h7777, 16'h8888, 2'b11, 2'b00);
    tick();
    setIn(0, 0, 2'd2, 1, 0, 0, 0, 0);
    tick();

    report();
    $finish;
  end
endmodule